// File: doc/BRIEF.md
# Serial Transmitter with Clear-to-Send Gating

This block turns bytes into asynchronous serial frames on a single output line. A byte goes first into a one-byte holding stage and then into a shift register. From there it is sent as one start bit, eight data bits with the least significant bit first, and one stop bit. Bit timing comes from an external tick. Each bit lasts sixteen ticks in oversampled mode and one tick in direct mode. Software-style commands turn the transmitter on and off. Two flags report its state: one shows that the holding stage can take a byte, and one shows that nothing is queued or in flight.

An optional flow-control mode makes the start of each character depend on an active-low clear-to-send input. That input is checked only where a character would begin, so a character that has already started always completes. When the transmitter leaves underrun, it waits a short arming window before the start bit. A disable command that arrives inside this window cancels the byte, and nothing reaches the line. A disable command that arrives after the start bit has begun lets that character finish, and any byte still waiting behind it is dropped. An inverted copy of the empty flag is provided for an output pin. It tells the far end that the last byte has left.

Top module: `cts_uart_tx`

## Requirements
- R1: After reset, `txd` is 1, `tx_rdy` is 0, `tx_emt` is 1, `emt_pin_n` is 0, and the transmitter is disabled.
- R2: A frame is a 0 start bit, then 8 data bits with the LSB first, then a 1 stop bit. Each bit lasts 16 `bit_tick` pulses when `x16_mode`=1 and 1 pulse when `x16_mode`=0. The idle line is 1.
- R3: `tx_rdy` is 1 exactly when the transmitter is enabled and the holding stage is empty. A load is taken only while `tx_rdy` is 1. Any other load is ignored and sets no flag.
- R4: When a byte is loaded from underrun, the start bit begins after an arming window of 3 ticks (`x16_mode`=1) or 1 tick (`x16_mode`=0). The byte moves to the shift register at the end of the start bit, and `tx_rdy` returns to 1 at that point.
- R5: A `tx_dis_cmd` that arrives before the start bit of a byte loaded from underrun has begun cancels that byte. Nothing is sent.
- R6: A `tx_dis_cmd` that arrives after the start bit has begun lets the current character finish. A byte still waiting in the holding stage is discarded.
- R7: `tx_emt` is 1 exactly when no character is arming or being sent and the holding stage is empty. `emt_pin_n` is always the inverse of `tx_emt`.
- R8: With `cts_gate_en`=1, a character starts only while the synchronised `cts_n` is 0. `cts_n` is examined only at character boundaries, so raising it during a character stops transmission after that character.
- R9: With `cts_gate_en`=0, `cts_n` has no effect.
- R10: If a byte is waiting when a stop bit ends and sending is allowed, its start bit follows at once with no arming window. Start bits of back-to-back frames are 10 bit times apart.
- R11: If `tx_en_cmd` and `tx_dis_cmd` arrive in the same cycle, the transmitter ends up disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | Bit-rate tick (16x or 1x the bit rate) |
| x16_mode | input | 1 | 1: sixteen ticks per bit, 0: one tick per bit |
| cts_gate_en | input | 1 | 1: clear-to-send gates character starts |
| cts_n | input | 1 | Active-low clear-to-send, asynchronous |
| tx_en_cmd | input | 1 | Enable command pulse |
| tx_dis_cmd | input | 1 | Disable command pulse |
| ld_valid | input | 1 | Byte load strobe |
| ld_data | input | 8 | Byte to load |
| txd | output | 1 | Serial output line |
| tx_rdy | output | 1 | Holding stage can accept a byte |
| tx_emt | output | 1 | Nothing queued, arming or in flight |
| emt_pin_n | output | 1 | Active-low empty indication for a pin |

## Verification
The bench attacks the disable window from both sides. A disable issued right after a load, or just before the start bit begins, must leave the line high. A design with a missing or misplaced window would emit a stray frame. A disable issued during the start bit or after `tx_rdy` returns must still deliver the active character but drop the queued one. A design that cleared everything at once would truncate the frame, and one that ignored the disable would send the second byte. Flow control is checked by raising `cts_n` in the middle of a character. A design that sampled it continuously would cut the frame, and one that never sampled it would send the next byte. The bench also measures exact start-bit timing, the moment `tx_rdy` returns, and the spacing of back-to-back frames, which exposes wrong arming or transfer points.

// File: rtl/cts_uart_tx_pkg.sv
package cts_uart_tx_pkg;
  typedef enum logic [2:0] {
    TX_IDLE  = 3'd0,
    TX_ARM   = 3'd1,
    TX_START = 3'd2,
    TX_DATA  = 3'd3,
    TX_STOP  = 3'd4
  } tx_state_e;
endpackage

// File: rtl/cts_sync.sv
module cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  generate
    if (STAGES <= 1) begin : g_one
      logic q;
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b1;
        else     q <= din;
      end
      assign dout = q;
    end else begin : g_chain
      logic [STAGES-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= '1;
        else     q <= {q[STAGES-2:0], din};
      end
      assign dout = q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/tx_hold_reg.sv
module tx_hold_reg #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en_cmd,
  input  logic                 dis_cmd,
  input  logic                 ld_valid,
  input  logic [DATA_BITS-1:0] ld_data,
  input  logic                 take,
  input  logic                 keep_on_dis,
  output logic                 enabled,
  output logic                 hold_full,
  output logic [DATA_BITS-1:0] hold_data
);
  logic accept;
  assign accept = ld_valid && enabled && !hold_full && !dis_cmd;

  always_ff @(posedge clk) begin
    if (rst) begin
      enabled <= 1'b0;
    end else if (dis_cmd) begin
      enabled <= 1'b0;
    end else if (en_cmd) begin
      enabled <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else if (take || (dis_cmd && !keep_on_dis)) begin
      hold_full <= 1'b0;
    end else if (accept) begin
      hold_full <= 1'b1;
      hold_data <= ld_data;
    end
  end

  // A load into an occupied stage leaves its contents untouched
  assert_busy_load_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && hold_full && !take && !dis_cmd) |=> ($stable(hold_data) && hold_full));

  // Disable wins over a simultaneous enable
  assert_dis_wins_R11: assert property (@(posedge clk) disable iff (rst)
    (en_cmd && dis_cmd) |=> !enabled);
endmodule

// File: rtl/tx_frame_fsm.sv
module tx_frame_fsm
  import cts_uart_tx_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int OVERSAMPLE = 16,
  parameter int ARM_X16    = 3,
  parameter int ARM_X1     = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bit_tick,
  input  logic                 x16_mode,
  input  logic                 enabled,
  input  logic                 dis_cmd,
  input  logic                 cts_ok,
  input  logic                 hold_full,
  input  logic [DATA_BITS-1:0] hold_data,
  output logic                 take,
  output tx_state_e            state_o,
  output logic                 txd
);
  localparam int CNT_W = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
  localparam int IDX_W = (DATA_BITS > 2) ? $clog2(DATA_BITS) : 1;
  localparam logic [CNT_W-1:0] BIT_LAST16 = CNT_W'(OVERSAMPLE - 1);
  localparam logic [CNT_W-1:0] ARM_LAST16 = CNT_W'(ARM_X16 - 1);
  localparam logic [CNT_W-1:0] ARM_LAST1  = CNT_W'(ARM_X1 - 1);
  localparam logic [IDX_W-1:0] IDX_LAST   = IDX_W'(DATA_BITS - 1);

  tx_state_e            state, state_n;
  logic [CNT_W-1:0]     cnt, cnt_n;
  logic [IDX_W-1:0]     idx, idx_n;
  logic [DATA_BITS-1:0] sh, sh_n;
  logic                 line_n;
  logic [CNT_W-1:0]     bit_last, arm_last;
  logic                 go;

  assign bit_last = x16_mode ? BIT_LAST16 : '0;
  assign arm_last = x16_mode ? ARM_LAST16 : ARM_LAST1;
  assign go       = hold_full && enabled && cts_ok && !dis_cmd;

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    idx_n   = idx;
    sh_n    = sh;
    take    = 1'b0;
    unique case (state)
      TX_IDLE: begin
        if (go) begin
          state_n = TX_ARM;
          cnt_n   = '0;
        end
      end
      TX_ARM: begin
        if (dis_cmd) begin
          state_n = TX_IDLE;
        end else if (bit_tick) begin
          if (cnt == arm_last) begin
            state_n = TX_START;
            cnt_n   = '0;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
      end
      TX_START: begin
        if (bit_tick) begin
          if (cnt == bit_last) begin
            state_n = TX_DATA;
            cnt_n   = '0;
            idx_n   = '0;
            sh_n    = hold_data;
            take    = 1'b1;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
      end
      TX_DATA: begin
        if (bit_tick) begin
          if (cnt == bit_last) begin
            cnt_n = '0;
            sh_n  = sh >> 1;
            if (idx == IDX_LAST) state_n = TX_STOP;
            else                 idx_n   = idx + 1'b1;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
      end
      TX_STOP: begin
        if (bit_tick) begin
          if (cnt == bit_last) begin
            cnt_n   = '0;
            state_n = go ? TX_START : TX_IDLE;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
      end
      default: state_n = TX_IDLE;
    endcase

    unique case (state_n)
      TX_START: line_n = 1'b0;
      TX_DATA:  line_n = sh_n[0];
      default:  line_n = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= TX_IDLE;
      cnt   <= '0;
      idx   <= '0;
      sh    <= '0;
      txd   <= 1'b1;
    end else begin
      state <= state_n;
      cnt   <= cnt_n;
      idx   <= idx_n;
      sh    <= sh_n;
      txd   <= line_n;
    end
  end

  assign state_o = state;

  // Disable while arming cancels before the line ever drops
  assert_arm_cancel_R5: assert property (@(posedge clk) disable iff (rst)
    (state == TX_ARM && dis_cmd) |=> (state == TX_IDLE && txd));

  // Disable in the middle of data bits does not cut the character
  assert_data_completes_R6: assert property (@(posedge clk) disable iff (rst)
    (state == TX_DATA && dis_cmd) |=> (state == TX_DATA || state == TX_STOP));

  // Line is low throughout a start bit
  assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
    (state == TX_START) |-> !txd);
endmodule

// File: rtl/cts_uart_tx.sv
module cts_uart_tx
  import cts_uart_tx_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int OVERSAMPLE  = 16,
  parameter int ARM_X16     = 3,
  parameter int ARM_X1      = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bit_tick,
  input  logic                 x16_mode,
  input  logic                 cts_gate_en,
  input  logic                 cts_n,
  input  logic                 tx_en_cmd,
  input  logic                 tx_dis_cmd,
  input  logic                 ld_valid,
  input  logic [DATA_BITS-1:0] ld_data,
  output logic                 txd,
  output logic                 tx_rdy,
  output logic                 tx_emt,
  output logic                 emt_pin_n
);
  logic                 cts_s;
  logic                 cts_ok;
  logic                 enabled;
  logic                 hold_full;
  logic [DATA_BITS-1:0] hold_data;
  logic                 take;
  tx_state_e            state;

  cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (cts_n),
    .dout(cts_s)
  );

  assign cts_ok = !cts_gate_en || !cts_s;

  tx_hold_reg #(.DATA_BITS(DATA_BITS)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .en_cmd     (tx_en_cmd),
    .dis_cmd    (tx_dis_cmd),
    .ld_valid   (ld_valid),
    .ld_data    (ld_data),
    .take       (take),
    .keep_on_dis(state == TX_START),
    .enabled    (enabled),
    .hold_full  (hold_full),
    .hold_data  (hold_data)
  );

  tx_frame_fsm #(
    .DATA_BITS (DATA_BITS),
    .OVERSAMPLE(OVERSAMPLE),
    .ARM_X16   (ARM_X16),
    .ARM_X1    (ARM_X1)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .bit_tick (bit_tick),
    .x16_mode (x16_mode),
    .enabled  (enabled),
    .dis_cmd  (tx_dis_cmd),
    .cts_ok   (cts_ok),
    .hold_full(hold_full),
    .hold_data(hold_data),
    .take     (take),
    .state_o  (state),
    .txd      (txd)
  );

  assign tx_rdy    = enabled && !hold_full;
  assign tx_emt    = (state == TX_IDLE) && !hold_full;
  assign emt_pin_n = !tx_emt;

  // A waiting byte stays put while clear-to-send is deasserted
  assert_cts_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (state == TX_IDLE && hold_full && enabled && cts_gate_en && cts_s) |=> (state == TX_IDLE));

  // Empty implies an idle-high line
  assert_empty_line_high_R7: assert property (@(posedge clk) disable iff (rst)
    tx_emt |-> txd);
endmodule

// File: tb/cts_uart_tx_tb.sv
`timescale 1ns/1ps
module cts_uart_tx_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_tick = 1'b1;
  logic       x16_mode = 1'b1;
  logic       cts_gate_en = 1'b0;
  logic       cts_n = 1'b0;
  logic       tx_en_cmd = 1'b0;
  logic       tx_dis_cmd = 1'b0;
  logic       ld_valid = 1'b0;
  logic [7:0] ld_data = '0;
  logic       txd, tx_rdy, tx_emt, emt_pin_n;

  always #2.5 clk = ~clk;

  cts_uart_tx u_dut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .x16_mode(x16_mode),
    .cts_gate_en(cts_gate_en), .cts_n(cts_n), .tx_en_cmd(tx_en_cmd),
    .tx_dis_cmd(tx_dis_cmd), .ld_valid(ld_valid), .ld_data(ld_data),
    .txd(txd), .tx_rdy(tx_rdy), .tx_emt(tx_emt), .emt_pin_n(emt_pin_n)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  int bit_cyc = 16;
  bit mon_busy = 0;
  logic [7:0] rx_q[$];
  int start_q[$];
  int frame_err = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Receiver model: samples each bit in its middle
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && txd === 1'b0) begin
        logic [7:0] b;
        mon_busy = 1;
        start_q.push_back(cyc);
        repeat (bit_cyc / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          repeat (bit_cyc) @(negedge clk);
          b[i] = txd;
        end
        repeat (bit_cyc) @(negedge clk);
        if (txd !== 1'b1) frame_err++;
        rx_q.push_back(b);
        mon_busy = 0;
      end
    end
  end

  task automatic pulse_en();
    @(negedge clk) tx_en_cmd = 1; @(negedge clk) tx_en_cmd = 0;
  endtask
  task automatic pulse_dis();
    @(negedge clk) tx_dis_cmd = 1; @(negedge clk) tx_dis_cmd = 0;
  endtask
  task automatic load(input logic [7:0] d);
    @(negedge clk) begin ld_valid = 1; ld_data = d; end
    @(negedge clk) ld_valid = 0;
  endtask
  task automatic set_mode(input bit m);
    x16_mode = m; bit_cyc = m ? 16 : 1;
  endtask
  task automatic wait_idle();
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (tx_emt && !mon_busy) break;
    end
    repeat (4) @(negedge clk);
  endtask
  task automatic wait_rdy();
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (tx_rdy) break;
    end
  endtask
  task automatic clear_rx();
    rx_q.delete(); start_q.delete();
  endtask

  // {x16_mode, byte}
  localparam logic [8:0] VEC [0:5] = '{9'h1A5, 9'h100, 9'h1FF, 9'h03C, 9'h081, 9'h15A};

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(txd == 1, "R1 txd", txd, 1);
    chk(tx_rdy == 0, "R1 tx_rdy", tx_rdy, 0);
    chk(tx_emt == 1, "R1 tx_emt", tx_emt, 1);
    chk(emt_pin_n == 0, "R1 emt_pin_n", emt_pin_n, 0);

    // R3: load while disabled is ignored
    load(8'h77);
    repeat (200) @(negedge clk);
    chk(rx_q.size() == 0, "R3 load while disabled", rx_q.size(), 0);
    chk(tx_emt == 1, "R3 no flag after ignored load", tx_emt, 1);

    pulse_en();
    chk(tx_rdy == 1, "R3 ready after enable", tx_rdy, 1);
    chk(tx_emt == 1, "R7 empty after enable", tx_emt, 1);

    // Vector table: frame format in both modes
    foreach (VEC[i]) begin
      set_mode(VEC[i][8]);
      clear_rx();
      load(VEC[i][7:0]);
      wait_idle();
      chk(rx_q.size() == 1 && rx_q[0] == VEC[i][7:0], "R2 frame byte",
          (rx_q.size() > 0) ? int'(rx_q[0]) : -1, VEC[i][7:0]);
      chk(frame_err == 0, "R2 stop bit", frame_err, 0);
      chk(tx_emt == 1 && emt_pin_n == 0, "R7 empty after frame", tx_emt, 1);
    end

    // R4: arming window and transfer point, 16x mode
    set_mode(1); clear_rx();
    load(8'h3C);
    repeat (3) @(negedge clk);
    chk(txd == 1, "R4 line high during arm x16", txd, 1);
    @(negedge clk);
    chk(txd == 0, "R4 start bit begins x16", txd, 0);
    repeat (15) @(negedge clk);
    chk(tx_rdy == 0, "R4 rdy low in start bit", tx_rdy, 0);
    @(negedge clk);
    chk(tx_rdy == 1, "R4 rdy after start bit", tx_rdy, 1);
    chk(txd == 0, "R4 first data bit LSB", txd, 0);
    wait_idle();

    // R4: 1x mode
    set_mode(0); clear_rx();
    load(8'h81);
    @(negedge clk);
    chk(txd == 1, "R4 line high during arm x1", txd, 1);
    @(negedge clk);
    chk(txd == 0, "R4 start bit begins x1", txd, 0);
    @(negedge clk);
    chk(tx_rdy == 1 && txd == 1, "R4 rdy after start x1", {tx_rdy, txd}, 3);
    wait_idle();

    // R5: disable right after load, 1x mode
    clear_rx();
    load(8'h11);
    @(negedge clk) tx_dis_cmd = 1; @(negedge clk) tx_dis_cmd = 0;
    repeat (100) @(negedge clk);
    chk(rx_q.size() == 0, "R5 cancel x1", rx_q.size(), 0);
    chk(tx_emt == 1 && tx_rdy == 0, "R5 flags after cancel", {tx_emt, tx_rdy}, 2);

    // R5: disable just before start, 16x mode
    set_mode(1); pulse_en(); clear_rx();
    load(8'h22);
    @(negedge clk);
    tx_dis_cmd = 1; @(negedge clk) tx_dis_cmd = 0;
    repeat (300) @(negedge clk);
    chk(rx_q.size() == 0, "R5 cancel x16", rx_q.size(), 0);

    // R6: disable during start bit: character finishes
    pulse_en(); clear_rx();
    load(8'h96);
    for (int k = 0; k < 100 && txd; k++) @(negedge clk);
    pulse_dis();
    wait_idle();
    chk(rx_q.size() == 1 && rx_q[0] == 8'h96, "R6 finish after start",
        (rx_q.size() > 0) ? int'(rx_q[0]) : -1, 8'h96);

    // R6: disable after rdy returns: active finishes, queued dropped
    pulse_en(); clear_rx();
    load(8'hC3);
    wait_rdy();
    load(8'h5D);
    pulse_dis();
    wait_idle();
    repeat (200) @(negedge clk);
    chk(rx_q.size() == 1, "R6 queued byte dropped", rx_q.size(), 1);
    chk(rx_q.size() > 0 && rx_q[0] == 8'hC3, "R6 active byte kept",
        (rx_q.size() > 0) ? int'(rx_q[0]) : -1, 8'hC3);

    // R3 and R10: busy load ignored, back-to-back spacing
    pulse_en(); clear_rx();
    load(8'hA1);
    load(8'hEE);
    wait_rdy();
    load(8'h4B);
    wait_idle();
    chk(rx_q.size() == 2, "R3 busy load ignored", rx_q.size(), 2);
    chk(rx_q.size() == 2 && rx_q[0] == 8'hA1 && rx_q[1] == 8'h4B, "R10 order",
        (rx_q.size() > 1) ? int'(rx_q[1]) : -1, 8'h4B);
    chk(start_q.size() == 2 && start_q[1] - start_q[0] == 160, "R10 spacing",
        (start_q.size() > 1) ? start_q[1] - start_q[0] : -1, 160);

    // R9: gating off, cts_n high has no effect
    clear_rx(); cts_gate_en = 0; cts_n = 1;
    load(8'h69);
    wait_idle();
    chk(rx_q.size() == 1 && rx_q[0] == 8'h69, "R9 cts ignored",
        (rx_q.size() > 0) ? int'(rx_q[0]) : -1, 8'h69);

    // R8: gating on, cts_n high blocks start
    clear_rx(); cts_gate_en = 1; cts_n = 1;
    repeat (5) @(negedge clk);
    load(8'h12);
    repeat (300) @(negedge clk);
    chk(rx_q.size() == 0 && txd == 1, "R8 blocked", rx_q.size(), 0);
    chk(tx_rdy == 0 && tx_emt == 0, "R8 flags while blocked", {tx_rdy, tx_emt}, 0);
    cts_n = 0;
    wait_idle();
    chk(rx_q.size() == 1 && rx_q[0] == 8'h12, "R8 released",
        (rx_q.size() > 0) ? int'(rx_q[0]) : -1, 8'h12);

    // R8: cts raised mid-character
    clear_rx();
    load(8'hF0);
    wait_rdy();
    load(8'h0F);
    repeat (40) @(negedge clk);
    cts_n = 1;
    repeat (400) @(negedge clk);
    chk(rx_q.size() == 1 && rx_q[0] == 8'hF0, "R8 current completes",
        (rx_q.size() > 0) ? int'(rx_q[0]) : -1, 8'hF0);
    chk(tx_rdy == 0 && txd == 1, "R8 next held", {tx_rdy, txd}, 1);
    cts_n = 0;
    wait_idle();
    chk(rx_q.size() == 2 && rx_q[1] == 8'h0F, "R8 next after release",
        (rx_q.size() > 1) ? int'(rx_q[1]) : -1, 8'h0F);
    cts_gate_en = 0;

    // R11: enable and disable together
    @(negedge clk) begin tx_en_cmd = 1; tx_dis_cmd = 1; end
    @(negedge clk) begin tx_en_cmd = 0; tx_dis_cmd = 0; end
    chk(tx_rdy == 0, "R11 disable wins", tx_rdy, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule